// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a single-port synchronous SRAM that starts a new read or write on every enabled clock edge. No idle cycles are needed when the bus turns from writing to reading or back. Address and control are registered on one edge. The matching data transfer happens in the following cycle: write data is taken at the edge that closes that cycle, and read data flows from the array to the outputs without an output register.

An internal two-bit beat counter lets one loaded address drive up to four data cycles. The counter steps the low address bits in linear or interleaved order. Each write carries four active-low byte-lane selects, and each lane is nine bits wide. Three chip selects gate new operations. An active-low clock-enable stalls the whole pipeline, and an asynchronous output enable can only turn the read drivers off. The bidirectional data bus is split into a data-in bus, a data-out bus and a drive-valid flag. The array depth is a parameter.

Top module: `zbt_flow_sram`

## Requirements
- R1: Address and control are sampled on an enabled edge; the data cycle for that operation is the following clock cycle, and write data is taken from `wdata` at the enabled edge that ends that data cycle.
- R2: Read data is combinational from the array during the data cycle. A read issued on the edge right after a write's address edge returns the newly written word, with no idle cycle between them.
- R3: While `clk_en_n` is 1, every synchronous input is ignored and all state holds: the current data cycle continues unchanged, and no write is committed.
- R4: A load (`adv`=0) starts an operation only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Otherwise the block goes idle, but a data cycle already in flight still completes.
- R5: `rdata_vld` is 0 during the data cycle that follows a deselect and during every write data cycle.
- R6: `adv`=1 during an operation issues the next beat with the same read/write type as the load and ignores `rd_wr`. With `burst_ilv`=0 the two low address bits are start+beat modulo 4 (start 1 gives 1,2,3,0).
- R7: With `burst_ilv`=1 the two low address bits are the start bits XOR the beat number 0,1,2,3 (start 1 gives 1,0,3,2). The upper address bits stay fixed in both orders.
- R8: `lane_we_n[i]`=0 writes bits [9i+8:9i] of the word. Lanes whose select is 1 keep their stored contents. The selects are sampled with each address cycle, whether load or advance.
- R9: `oe_n`=1 forces `rdata_vld` to 0 immediately, without a clock edge, and has no other effect.
- R10: `adv`=1 while idle is a continued deselect: no data cycle and no counter movement.
- R11: During and right after reset, no data cycle is active and `rdata_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable; 1 stalls the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write (sampled on load) |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| lane_we_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | LANES*LANE_W | Write data for the current data cycle |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
On every cycle the assertions check four things. An accepted load produces a data cycle one edge later. A deselected load or an idle advance produces none. A stalled edge freezes the data-phase state. The drive flag never rises during a write or idle data cycle, or while the output enable is off. Read values, burst address orders, lane merging, stalls that span a write's data cycle, and write-then-read with no idle cycle are shown only by the bench's scenarios. In those scenarios, each data cycle is compared against a reference memory that the bench keeps from the requirements.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for a given beat of a burst.
  function automatic beat_t beat_low(beat_t start, beat_t beat, logic ilv);
    return ilv ? (start ^ beat) : beat_t'(start + beat);
  endfunction

  // All three chip selects must be active together.
  function automatic logic chip_selected(logic s0_n, logic s1, logic s2_n);
    return !s0_n && s1 && !s2_n;
  endfunction
endpackage

// File: rtl/zbt_addr_seq.sv
module zbt_addr_seq
  import zbt_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          load,
  input  logic          sel_ok,
  input  logic          rd_req,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output logic          iss_vld,
  output logic          iss_rd,
  output logic [AW-1:0] iss_addr,
  output logic          active,
  output logic          op_start
);
  logic          op_rd;
  logic [AW-1:0] base;
  beat_t         beat;
  logic [AW-1:0] iss_base;
  beat_t         iss_beat;

  always_comb begin
    op_start = load && sel_ok;
    if (load) begin
      iss_vld  = sel_ok;
      iss_rd   = rd_req;
      iss_base = addr;
      iss_beat = '0;
    end else begin
      iss_vld  = active;
      iss_rd   = op_rd;
      iss_base = base;
      iss_beat = beat_t'(beat + 1'b1);
    end
    iss_addr = {iss_base[AW-1:BEAT_W], beat_low(iss_base[BEAT_W-1:0], iss_beat, ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      op_rd  <= 1'b0;
      base   <= '0;
      beat   <= '0;
    end else if (adv_en) begin
      if (load) begin
        active <= sel_ok;
        if (sel_ok) begin
          op_rd <= rd_req;
          base  <= addr;
          beat  <= '0;
        end
      end else if (active) begin
        beat <= iss_beat;
      end
    end
  end
endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wlane_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] bit_mask;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bit_mask[l*LANE_W +: LANE_W] = {LANE_W{!wlane_n[l]}};
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= (mem[waddr] & ~bit_mask) | (wdata & bit_mask);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/zbt_flow_sram.sv
module zbt_flow_sram
  import zbt_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    adv,
  input  logic                    rd_wr,
  input  logic                    burst_ilv,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);
  localparam int W = LANES * LANE_W;

  logic          adv_en, load, sel_ok;
  logic          iss_vld, iss_rd, seq_active, op_start;
  logic [AW-1:0] iss_addr;
  logic          d_valid, d_rd;
  logic [AW-1:0] d_addr;
  logic [LANES-1:0] d_lane_n;
  logic          wr_fire;
  logic [W-1:0]  arr_rd;

  assign adv_en = !clk_en_n;
  assign load   = !adv;
  assign sel_ok = chip_selected(sel0_n, sel1, sel2_n);

  zbt_addr_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .load     (load),
    .sel_ok   (sel_ok),
    .rd_req   (rd_wr),
    .ilv      (burst_ilv),
    .addr     (addr),
    .iss_vld  (iss_vld),
    .iss_rd   (iss_rd),
    .iss_addr (iss_addr),
    .active   (seq_active),
    .op_start (op_start)
  );

  // Data-phase registers: one cycle behind the address phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid  <= 1'b0;
      d_rd     <= 1'b0;
      d_addr   <= '0;
      d_lane_n <= '1;
    end else if (adv_en) begin
      d_valid  <= iss_vld;
      d_rd     <= iss_rd;
      d_addr   <= iss_addr;
      d_lane_n <= lane_we_n;
    end
  end

  assign wr_fire = adv_en && d_valid && !d_rd;

  zbt_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .we      (wr_fire),
    .waddr   (d_addr),
    .wlane_n (d_lane_n),
    .wdata   (wdata),
    .raddr   (d_addr),
    .rdata   (arr_rd)
  );

  assign rdata_vld = d_valid && d_rd && !oe_n;
  assign rdata     = rdata_vld ? arr_rd : '0;
endmodule

// File: rtl/zbt_flow_sram_chk.sv
module zbt_flow_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          adv,
  input logic          sel_ok,
  input logic          oe_n,
  input logic          seq_active,
  input logic          op_start,
  input logic          d_valid,
  input logic          d_rd,
  input logic [AW-1:0] d_addr,
  input logic          rdata_vld
);
  a_r1_data_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && op_start) |=> d_valid);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(d_valid) && $stable(d_rd) && $stable(d_addr)));

  a_r4_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && !sel_ok) |=> !d_valid);

  a_r5_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_valid || !d_rd) |-> !rdata_vld);

  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_vld);

  a_r10_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && !seq_active) |=> (!seq_active && !d_valid));
endmodule

bind zbt_flow_sram zbt_flow_sram_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en_n   (clk_en_n),
  .adv        (adv),
  .sel_ok     (sel_ok),
  .oe_n       (oe_n),
  .seq_active (seq_active),
  .op_start   (op_start),
  .d_valid    (d_valid),
  .d_rd       (d_rd),
  .d_addr     (d_addr),
  .rdata_vld  (rdata_vld)
);

// File: tb/zbt_flow_sram_tb.sv
`timescale 1ns/1ps
module zbt_flow_sram_tb;
  localparam int AW = 6, LANES = 4, LANE_W = 9, W = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic adv = 1'b0, rd_wr = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LANES-1:0] lane_we_n = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic rdata_vld;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  zbt_flow_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .adv(adv), .rd_wr(rd_wr), .burst_ilv(burst_ilv), .addr(addr),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  // Reference model state, built from the requirements.
  logic [W-1:0] mm [DEPTH];
  logic m_act = 0, m_rd = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_beat = '0;
  logic dp_v = 0, dp_rd = 0;
  logic [AW-1:0] dp_a = '0;
  logic [LANES-1:0] dp_ln = '1;

  // Scoreboard queues.
  bit q_vld [$];
  logic [W-1:0] q_dat [$];
  string q_tag [$];

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, logic [1:0] n, logic ilv);
    logic [1:0] lo;
    if (ilv) lo = b[1:0] ^ n;
    else     lo = b[1:0] + n;
    return {b[AW-1:2], lo};
  endfunction

  task automatic note(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic step(input logic en_n, input logic a, input logic [2:0] sels,
                      input logic rw, input logic [AW-1:0] ad, input logic [LANES-1:0] ln,
                      input logic [W-1:0] wd, input string tag);
    logic iss, ird, sok;
    logic [AW-1:0] ia;
    @(negedge clk);
    clk_en_n = en_n; adv = a; {sel0_n, sel1, sel2_n} = sels;
    rd_wr = rw; addr = ad; lane_we_n = ln; wdata = wd;
    @(posedge clk);
    if (!en_n) begin
      if (dp_v && !dp_rd)
        for (int l = 0; l < LANES; l++)
          if (!dp_ln[l]) mm[dp_a][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
      sok = (sels == 3'b010);
      if (!a) begin
        iss = sok; ird = rw; ia = ad;
        m_act = sok;
        if (sok) begin m_rd = rw; m_base = ad; m_beat = 2'd0; end
      end else begin
        iss = m_act; ird = m_rd;
        if (m_act) m_beat = m_beat + 2'd1;
        ia = beat_addr(m_base, m_beat, burst_ilv);
      end
      dp_v = iss; dp_rd = ird; dp_a = ia; dp_ln = ln;
    end
    q_vld.push_back(dp_v && dp_rd);
    q_dat.push_back(mm[dp_a]);
    q_tag.push_back(tag);
  endtask

  task automatic ld(input logic rw, input logic [AW-1:0] ad, input logic [W-1:0] wd, input string tag);
    step(1'b0, 1'b0, 3'b010, rw, ad, '0, wd, tag);
  endtask
  task automatic nx(input logic rw, input logic [W-1:0] wd, input string tag);
    step(1'b0, 1'b1, 3'b010, rw, '0, '0, wd, tag);
  endtask
  task automatic nop(input logic [W-1:0] wd, input string tag);
    step(1'b0, 1'b0, 3'b110, 1'b1, '0, '0, wd, tag);
  endtask

  // Monitor: compare each data cycle mid-cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_vld.size() > 0) begin
        bit ev;
        logic [W-1:0] ed;
        string tg;
        ev = q_vld.pop_front(); ed = q_dat.pop_front(); tg = q_tag.pop_front();
        if (rdata_vld !== ev)
          note(1'b0, tg, $sformatf("rdata_vld actual=%0b expected=%0b", rdata_vld, ev));
        else if (ev && rdata !== ed)
          note(1'b0, tg, $sformatf("rdata actual=%h expected=%h", rdata, ed));
        else
          note(1'b1, tg, "");
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    note(rdata_vld === 1'b0, "R11", $sformatf("reset rdata_vld actual=%0b expected=0", rdata_vld));
    @(negedge clk);
    rst_n = 1'b1;
    nop('0, "R11");

    // R1/R2: writes, reads, write then read with no idle cycle.
    ld(1'b0, 6'd8, '0, "R1");
    ld(1'b0, 6'd9, 36'hA_1111_2222, "R1");
    ld(1'b1, 6'd8, 36'hB_3333_4444, "R1");
    ld(1'b1, 6'd9, '0, "R1");
    ld(1'b0, 6'd8, '0, "R2");
    ld(1'b1, 6'd8, 36'hC_5555_6666, "R2");
    nop('0, "R2");

    // Fill 16..19 for burst order checks.
    ld(1'b0, 6'd16, '0, "R1");
    ld(1'b0, 6'd17, 36'h0_0000_0016, "R1");
    ld(1'b0, 6'd18, 36'h0_0000_0017, "R1");
    ld(1'b0, 6'd19, 36'h0_0000_0018, "R1");
    nop(36'h0_0000_0019, "R1");

    // R6: linear burst read from 17, rd_wr driven to write (ignored).
    ld(1'b1, 6'd17, '0, "R6");
    nx(1'b0, '0, "R6");
    nx(1'b0, '0, "R6");
    nx(1'b0, '0, "R6");
    nop('0, "R6");

    // R7: interleaved burst read from 17.
    burst_ilv = 1'b1;
    ld(1'b1, 6'd17, '0, "R7");
    nx(1'b1, '0, "R7");
    nx(1'b1, '0, "R7");
    nx(1'b1, '0, "R7");
    nop('0, "R7");
    burst_ilv = 1'b0;

    // R6: linear burst write from 25, rd_wr driven to read (ignored).
    ld(1'b0, 6'd25, '0, "R6");
    nx(1'b1, 36'hD_0000_0025, "R6");
    nx(1'b1, 36'hD_0000_0026, "R6");
    nx(1'b1, 36'hD_0000_0027, "R6");
    ld(1'b1, 6'd24, 36'hD_0000_0024, "R6");
    ld(1'b1, 6'd25, '0, "R6");
    ld(1'b1, 6'd27, '0, "R6");
    nop('0, "R6");

    // R8: partial lane write (lanes 0 and 2 written).
    ld(1'b0, 6'd32, '0, "R8");
    step(1'b0, 1'b0, 3'b010, 1'b0, 6'd32, 4'b1010, 36'hF_FFFF_FFFF, "R8");
    ld(1'b1, 6'd32, 36'h1_2345_6789, "R8");
    nop('0, "R8");

    // R4/R5: read in flight completes across a deselect; each select alone blocks.
    ld(1'b1, 6'd8, '0, "R4");
    step(1'b0, 1'b0, 3'b000, 1'b1, 6'd9, '0, '0, "R4");
    step(1'b0, 1'b0, 3'b011, 1'b1, 6'd9, '0, '0, "R5");
    step(1'b0, 1'b0, 3'b110, 1'b1, 6'd9, '0, '0, "R5");

    // R10: advance while idle with write type and data: no cycle, no write.
    nx(1'b0, 36'h9_9999_9999, "R10");
    nx(1'b0, 36'h9_9999_9999, "R10");
    ld(1'b1, 6'd8, 36'h9_9999_9999, "R10");
    nop('0, "R10");

    // R3: stall during a read data cycle and during a write data cycle.
    ld(1'b1, 6'd16, '0, "R3");
    step(1'b1, 1'b0, 3'b010, 1'b0, 6'd17, '0, 36'h7_7777_7777, "R3");
    step(1'b1, 1'b1, 3'b010, 1'b0, 6'd17, '0, 36'h7_7777_7777, "R3");
    ld(1'b0, 6'd40, '0, "R3");
    step(1'b1, 1'b0, 3'b010, 1'b1, 6'd17, '0, 36'h6_6666_6666, "R3");
    ld(1'b1, 6'd40, 36'h5_0000_0040, "R3");
    ld(1'b1, 6'd17, '0, "R3");
    nop('0, "R3");

    // R9: output enable acts between edges during a read data cycle.
    ld(1'b1, 6'd16, '0, "R9");
    #1.5;
    oe_n = 1'b1;
    #0.2;
    note(rdata_vld === 1'b0, "R9", $sformatf("oe off rdata_vld actual=%0b expected=0", rdata_vld));
    oe_n = 1'b0;
    #0.2;
    note(rdata_vld === 1'b1 && rdata === mm[16], "R9",
         $sformatf("oe on actual=%0b/%h expected=1/%h", rdata_vld, rdata, mm[16]));
    nop('0, "R9");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule